// File: doc/BRIEF.md
# EDID Fetch and Checksum Sequencer

This block reads a display's EDID image over a simple byte-wide request/acknowledge port. That port stands in for an I2C or AUX master. On a start pulse, the block first reads the extension-count byte of the base block. It then fetches the 128-byte base block and, when the count is non-zero, the first extension block as well. Each block is validated by its modulo-256 byte sum.

Once the block or blocks are valid, the sequencer reads the sink's test-request register. If the sink asks for an EDID-read test, the block answers in two steps. It writes the checksum byte of the last block it fetched to the sink's test-checksum register. It then sets the checksum-written flag in the sink's test-response register.

Any failed read ends the run. A read counts as failed if the port reports an error or gives no acknowledge within the programmable timeout. A bad block sum also ends the run. The result is reported by a one-cycle done pulse carrying an error code.

Top module: `edid_fetch_seq`

## Requirements
- R1: After reset, `done` is low, `err_code` is 0 and `req_valid` is low until `start` is seen.
- R2: The first request after `start` is a read (`req_write`=0, `req_sink`=0, `req_dev`=0x50) at EDID offset 0x7E, the extension-count byte.
- R3: When the extension count is zero, EDID offsets 0 to 127 are read in ascending order. When it is non-zero, offsets 0 to 255 are read in ascending order. Every EDID read uses device 0x50.
- R4: A block whose 128 bytes do not sum to zero modulo 256 ends the run with `err_code`=2. No further request is issued after that.
- R5: After the blocks validate, the sink register at address 0x218 is read (`req_sink`=1). If bit 2 of that register is set, two writes follow: the last block's byte at offset 127 goes to sink address 0x261, then the value 0x04 goes to sink address 0x260. If bit 2 is clear, no write is made, whatever the other bits hold.
- R6: An acknowledge that arrives with `req_err` high ends the run with `err_code`=1. No further request is issued after that.
- R7: A request that receives no acknowledge for more than `tmo_limit` cycles is withdrawn (`req_valid` falls). The run then ends with `err_code`=1.
- R8: `done` is high for exactly one cycle per run. `err_code` is 0 on success and is valid in the cycle `done` is high.
- R9: While `req_valid` is high and unacknowledged, `req_write`, `req_addr` and `req_wdata` hold steady. The only exception is a timeout.
- R10: A `start` pulse while a run is in progress is ignored. The run continues unchanged and gives a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch run (ignored while busy) |
| tmo_limit | input | 16 | Acknowledge timeout in cycles |
| req_valid | output | 1 | Request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_sink | output | 1 | 1 = sink register space, 0 = EDID device |
| req_dev | output | 7 | I2C device address (0x50 for EDID, 0 otherwise) |
| req_addr | output | 20 | Byte offset or sink register address |
| req_wdata | output | 8 | Write data |
| req_ack | input | 1 | Request completed this cycle |
| req_err | input | 1 | Completed request failed (valid with req_ack) |
| req_rdata | input | 8 | Read data (valid with req_ack) |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 read failure, 2 checksum failure |

## Verification
Each request rises one cycle after the sequencer decides to issue it. The request completes on the edge where the acknowledge is sampled. `done` and `err_code` are due on the cycle after the edge that accepts the final acknowledge. For a checksum failure, they are due two cycles after the last byte of the block is accepted.

The bench's responder acknowledges one cycle after it sees a request and logs every completed transfer on that same edge. The bench polls `done` at falling edges, where all registered outputs are settled. It samples `err_code` in the cycle `done` is found, then watches several further cycles to confirm the pulse lasts one cycle and that no request follows an abort.

// File: rtl/edid_pkg.sv
package edid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXT,
    ST_FETCH,
    ST_CHK,
    ST_TREQ,
    ST_WCK,
    ST_WFLG
  } seq_st_t;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_READ = 2'd1,
    ERR_SUM  = 2'd2
  } err_t;

  // Running modulo-256 sum step.
  function automatic logic [7:0] csum_add(input logic [7:0] s, input logic [7:0] b);
    return s + b;
  endfunction

  // Byte offset of a block entry within the EDID device.
  function automatic logic [8:0] blk_offset(input logic blk, input logic [6:0] idx,
                                            input int unsigned blk_bytes);
    return (blk ? 9'(blk_bytes) : 9'd0) + {2'b00, idx};
  endfunction

endpackage

// File: rtl/edid_ckacc.sv
module edid_ckacc
  import edid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] sum,
  output logic       sum_zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= 8'd0;
    else if (clr) sum <= 8'd0;
    else if (add) sum <= csum_add(sum, din);
  end

  assign sum_zero = (sum == 8'd0);

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> sum == 8'd0);

endmodule

// File: rtl/edid_xfer.sv
module edid_xfer #(
  parameter int AW = 20,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_wr,
  input  logic          go_sink,
  input  logic [AW-1:0] go_addr,
  input  logic [7:0]    go_wdata,
  input  logic [TW-1:0] tmo_limit,
  output logic          req_valid,
  output logic          req_write,
  output logic          req_sink,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_wdata,
  input  logic          req_ack,
  input  logic          req_err,
  output logic          xf_ok,
  output logic          xf_fail
);

  logic [TW-1:0] wait_cnt;
  logic          tmo_hit;

  assign tmo_hit = req_valid && !req_ack && (wait_cnt == tmo_limit);
  assign xf_ok   = req_valid && req_ack && !req_err;
  assign xf_fail = (req_valid && req_ack && req_err) || tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_sink  <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      wait_cnt  <= '0;
    end else if (go) begin
      req_valid <= 1'b1;
      req_write <= go_wr;
      req_sink  <= go_sink;
      req_addr  <= go_addr;
      req_wdata <= go_wdata;
      wait_cnt  <= '0;
    end else if (req_valid) begin
      if (req_ack || tmo_hit) req_valid <= 1'b0;
      else                    wait_cnt  <= wait_cnt + 1'b1;
    end
  end

  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack && !tmo_hit) |=>
      (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));

  // R7
  tmo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !req_valid);

  // R7
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> wait_cnt <= tmo_limit);

endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
  import edid_pkg::*;
#(
  parameter int          AW         = 20,
  parameter int          TW         = 16,
  parameter int          BLK_BYTES  = 128,
  parameter logic [6:0]  EDID_DEV   = 7'h50,
  parameter logic [7:0]  EXT_OFF    = 8'h7E,
  parameter logic [19:0] TREQ_ADDR  = 20'h00218,
  parameter int          TREQ_BIT   = 2,
  parameter logic [19:0] CKREG_ADDR = 20'h00261,
  parameter logic [19:0] RESP_ADDR  = 20'h00260,
  parameter logic [7:0]  RESP_FLAG  = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] tmo_limit,
  output logic          req_valid,
  output logic          req_write,
  output logic          req_sink,
  output logic [6:0]    req_dev,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_wdata,
  input  logic          req_ack,
  input  logic          req_err,
  input  logic [7:0]    req_rdata,
  output logic          done,
  output logic [1:0]    err_code
);

  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_BYTES - 1);

  seq_st_t        st;
  logic           issued;
  logic           blk;
  logic           two_blk;
  logic [IDX_W-1:0] idx;
  logic [7:0]     last_ck;
  err_t           err_q;

  logic           go, go_wr, go_sink;
  logic [AW-1:0]  go_addr;
  logic [7:0]     go_wdata;
  logic           xf_ok, xf_fail;
  logic           ck_clr, ck_add, ck_zero, ck_fail, ck_next_blk;
  logic [7:0]     ck_sum;
  logic           run_begin;

  // Named events for the checks below.
  assign run_begin   = (st == ST_IDLE) && start;
  assign ck_fail     = (st == ST_CHK) && !ck_zero;
  assign ck_next_blk = (st == ST_CHK) && ck_zero && two_blk && !blk;
  assign ck_clr      = run_begin || ck_next_blk;
  assign ck_add      = (st == ST_FETCH) && xf_ok;

  assign go = !issued && (st == ST_EXT || st == ST_FETCH || st == ST_TREQ ||
                          st == ST_WCK || st == ST_WFLG);

  always_comb begin
    go_wr    = 1'b0;
    go_sink  = 1'b0;
    go_addr  = '0;
    go_wdata = 8'd0;
    unique case (st)
      ST_EXT:   go_addr = AW'(EXT_OFF);
      ST_FETCH: go_addr = AW'(blk_offset(blk, 7'(idx), BLK_BYTES));
      ST_TREQ: begin
        go_sink = 1'b1;
        go_addr = AW'(TREQ_ADDR);
      end
      ST_WCK: begin
        go_sink  = 1'b1;
        go_wr    = 1'b1;
        go_addr  = AW'(CKREG_ADDR);
        go_wdata = last_ck;
      end
      ST_WFLG: begin
        go_sink  = 1'b1;
        go_wr    = 1'b1;
        go_addr  = AW'(RESP_ADDR);
        go_wdata = RESP_FLAG;
      end
      default: ;
    endcase
  end

  edid_xfer #(.AW(AW), .TW(TW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_wr     (go_wr),
    .go_sink   (go_sink),
    .go_addr   (go_addr),
    .go_wdata  (go_wdata),
    .tmo_limit (tmo_limit),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_sink  (req_sink),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ack   (req_ack),
    .req_err   (req_err),
    .xf_ok     (xf_ok),
    .xf_fail   (xf_fail)
  );

  edid_ckacc u_ck (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ck_clr),
    .add      (ck_add),
    .din      (req_rdata),
    .sum      (ck_sum),
    .sum_zero (ck_zero)
  );

  assign req_dev  = req_sink ? 7'd0 : EDID_DEV;
  assign err_code = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      issued  <= 1'b0;
      blk     <= 1'b0;
      two_blk <= 1'b0;
      idx     <= '0;
      last_ck <= 8'd0;
      done    <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      done  <= 1'b0;
      err_q <= ERR_NONE;
      if (go) issued <= 1'b1;
      if (xf_fail) begin
        issued <= 1'b0;
        st     <= ST_IDLE;
        done   <= 1'b1;
        err_q  <= ERR_READ;
      end else if (xf_ok) begin
        issued <= 1'b0;
        unique case (st)
          ST_EXT: begin
            two_blk <= (req_rdata != 8'd0);
            blk     <= 1'b0;
            idx     <= '0;
            st      <= ST_FETCH;
          end
          ST_FETCH: begin
            if (idx == IDX_LAST) begin
              last_ck <= req_rdata;
              st      <= ST_CHK;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          ST_TREQ: begin
            if (req_rdata[TREQ_BIT]) st <= ST_WCK;
            else begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          end
          ST_WCK: st <= ST_WFLG;
          ST_WFLG: begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
          default: ;
        endcase
      end else begin
        unique case (st)
          ST_IDLE: if (start) st <= ST_EXT;
          ST_CHK: begin
            if (!ck_zero) begin
              st    <= ST_IDLE;
              done  <= 1'b1;
              err_q <= ERR_SUM;
            end else if (ck_next_blk) begin
              blk <= 1'b1;
              idx <= '0;
              st  <= ST_FETCH;
            end else begin
              st <= ST_TREQ;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  sum_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_fail |=> (done && err_code == 2'd2));

  // R6
  rd_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xf_fail |=> (done && err_code == 2'd1));

  // R4
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code != 2'd0) |-> !req_valid);

  // R2
  first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_begin |=> !req_valid);

endmodule

// File: tb/sim_edid_fetch_seq.sv
module sim_edid_fetch_seq;

  localparam int AW = 20;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [TW-1:0] tmo_limit = 16'd20;
  logic          req_valid, req_write, req_sink;
  logic [6:0]    req_dev;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_wdata;
  logic          req_ack = 1'b0;
  logic          req_err = 1'b0;
  logic [7:0]    req_rdata = 8'd0;
  logic          done;
  logic [1:0]    err_code;

  always #10 clk = ~clk;

  edid_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tmo_limit(tmo_limit),
    .req_valid(req_valid), .req_write(req_write), .req_sink(req_sink),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_err(req_err), .req_rdata(req_rdata),
    .done(done), .err_code(err_code)
  );

  int vectors = 0;
  int miscompares = 0;

  // Responder state and logs
  logic [7:0]  edid [256];
  logic [7:0]  treq = 8'd0;
  logic        mute = 1'b0;
  int          err_at = -1;
  int          nrd = 0;
  int          nwr = 0;
  int          bad_dev = 0;
  logic [AW:0] rlog [300];
  logic [AW-1:0] wa [4];
  logic [7:0]  wd [4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : responder
    forever begin
      @(posedge clk);
      if (req_valid && req_ack) begin
        if (req_write) begin
          if (nwr < 4) begin wa[nwr] = req_addr; wd[nwr] = req_wdata; end
          nwr = nwr + 1;
        end else begin
          if (nrd < 300) rlog[nrd] = {req_sink, req_addr};
          if (!req_sink && req_dev != 7'h50) bad_dev = bad_dev + 1;
          nrd = nrd + 1;
        end
      end
      req_ack   <= req_valid && !req_ack && !mute;
      req_err   <= req_valid && !req_ack && !mute && ((nrd + nwr) == err_at);
      req_rdata <= req_sink ? ((req_addr == 20'h218) ? treq : 8'h00) : edid[req_addr[7:0]];
    end
  end

  task automatic fill(input int blk, input int seed, input logic [7:0] extc);
    logic [7:0] s;
    s = 8'd0;
    for (int i = 0; i < 127; i++) begin
      edid[blk*128 + i] = 8'((seed * 37 + i * 11 + 3) & 8'hFF);
      if (blk == 0 && i == 126) edid[126] = extc;
      s = s + edid[blk*128 + i];
    end
    edid[blk*128 + 127] = 8'(0) - s;
  endtask

  // Run one sequence; returns error code and number of done pulses seen.
  task automatic run(input int poke_at, output logic [1:0] ec, output int pulses, output bit got);
    nrd = 0; nwr = 0; bad_dev = 0;
    pulses = 0; got = 0; ec = 2'd0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 5000 && !got; c++) begin
      if (c == poke_at) start = 1'b1; else start = 1'b0;
      @(negedge clk);
      if (done) begin got = 1; ec = err_code; pulses++; end
    end
    start = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (done) pulses++;
      if (req_valid) pulses += 100;
    end
    if (!got) chk(0, "watchdog", 0, 1);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R1 done", done, 0);
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
    chk(err_code == 2'd0, "R1 err_code", err_code, 0);
  endtask

  task automatic t_one_block();
    logic [1:0] ec; int p; bit g; bit ord;
    fill(0, 1, 8'd0); treq = 8'hFB;
    run(-1, ec, p, g);
    chk(ec == 2'd0, "R8 ok code", ec, 0);
    chk(p == 1, "R8 single pulse", p, 1);
    chk(nrd == 130, "R3 one-block reads", nrd, 130);
    chk(rlog[0] == 21'h0007E, "R2 first read ext byte", int'(rlog[0]), 'h7E);
    ord = 1;
    for (int i = 0; i < 128; i++) if (rlog[i+1] != 21'(i)) ord = 0;
    chk(ord, "R3 ascending offsets", ord, 1);
    chk(bad_dev == 0, "R3 device 0x50", bad_dev, 0);
    chk(rlog[129] == {1'b1, 20'h218}, "R5 test request read", int'(rlog[129]), 'h100218);
    chk(nwr == 0, "R5 bit2 clear no write", nwr, 0);
  endtask

  task automatic t_two_block_test();
    logic [1:0] ec; int p; bit g; bit ord;
    fill(0, 2, 8'd1); fill(1, 5, 8'd0); treq = 8'h04;
    run(-1, ec, p, g);
    chk(ec == 2'd0, "R8 ok code two", ec, 0);
    chk(nrd == 258, "R3 two-block reads", nrd, 258);
    ord = 1;
    for (int i = 0; i < 256; i++) if (rlog[i+1] != 21'(i)) ord = 0;
    chk(ord, "R3 ascending 0..255", ord, 1);
    chk(nwr == 2, "R5 write count", nwr, 2);
    chk(wa[0] == 20'h261 && wd[0] == edid[255], "R5 checksum write", int'(wd[0]), int'(edid[255]));
    chk(wa[1] == 20'h260 && wd[1] == 8'h04, "R5 flag write", int'(wd[1]), 4);
  endtask

  task automatic t_one_block_test();
    logic [1:0] ec; int p; bit g;
    fill(0, 9, 8'd0); treq = 8'h04;
    run(-1, ec, p, g);
    chk(nwr == 2 && wd[0] == edid[127], "R5 block0 checksum write", int'(wd[0]), int'(edid[127]));
  endtask

  task automatic t_bad_block0();
    logic [1:0] ec; int p; bit g;
    fill(0, 3, 8'd1); fill(1, 4, 8'd0); edid[5] = edid[5] + 8'd1; treq = 8'h04;
    run(-1, ec, p, g);
    chk(ec == 2'd2, "R4 bad block0 code", ec, 2);
    chk(nrd == 129, "R4 abort after block0", nrd, 129);
    chk(nwr == 0, "R4 no write after abort", nwr, 0);
    chk(p == 1, "R4 quiet after abort", p, 1);
  endtask

  task automatic t_bad_block1();
    logic [1:0] ec; int p; bit g;
    fill(0, 6, 8'd2); fill(1, 7, 8'd0); edid[200] = edid[200] ^ 8'h10; treq = 8'h00;
    run(-1, ec, p, g);
    chk(ec == 2'd2, "R4 bad block1 code", ec, 2);
    chk(nrd == 257, "R4 abort after block1", nrd, 257);
  endtask

  task automatic t_rd_err();
    logic [1:0] ec; int p; bit g;
    fill(0, 8, 8'd0); treq = 8'h00; err_at = 40;
    run(-1, ec, p, g);
    err_at = -1;
    chk(ec == 2'd1, "R6 read error code", ec, 1);
    chk(nrd == 41, "R6 abort after error", nrd, 41);
    chk(p == 1, "R6 no request after abort", p, 1);
  endtask

  task automatic t_timeout();
    logic [1:0] ec; int p; bit g;
    fill(0, 8, 8'd0); mute = 1'b1;
    run(-1, ec, p, g);
    mute = 1'b0;
    chk(ec == 2'd1, "R7 timeout code", ec, 1);
    chk(nrd == 0, "R7 no completed read", nrd, 0);
    chk(p == 1, "R7 request withdrawn", p, 1);
  endtask

  task automatic t_busy_start();
    logic [1:0] ec; int p; bit g;
    fill(0, 11, 8'd0); treq = 8'h00;
    run(50, ec, p, g);
    chk(nrd == 130, "R10 run unchanged", nrd, 130);
    chk(p == 1, "R10 single done", p, 1);
    chk(ec == 2'd0, "R10 ok code", ec, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_one_block();
    t_two_block_test();
    t_one_block_test();
    t_bad_block0();
    t_bad_block1();
    t_rd_err();
    t_timeout();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule